// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo serial audio as a slave. It oversamples an external bit clock, word clock and data line with its own faster system clock. It turns each left/right pair into two parallel words and marks each pair with a single-cycle valid pulse. A 7-bit mode register picks one of three framings: left-justified, right-justified or I2S. The same register picks one of three word lengths (16, 18 or 20 bits) and the bit-clock ratio. Every received word is placed at the top of a 32-bit output, and the bits below it read as zero.

The external lines pass through a two-stage synchronizer. A deserializer detects bit-clock rising edges and word-clock transitions in the system-clock domain. It picks the bits that belong to the sample for the selected framing and hands one finished half-frame word to a controller at each word-clock transition.

The controller is a four-state machine:
- ST_WAIT: idle after reset.
- ST_SKIP: discarding a right half that had no left half before it.
- ST_LEFT: collecting the left half.
- ST_RIGHT: collecting the right half.

It moves only when a half-frame completes:
- ST_LEFT goes to ST_RIGHT when the finished half was a left one, and the left word is held.
- ST_RIGHT goes to ST_LEFT when the finished half was a right one, and the pair is emitted.
- ST_WAIT and ST_SKIP, and a state that sees the wrong channel finish, go to ST_SKIP if a left half just finished and to ST_LEFT if a right half just finished.

Top module: `pcm_rx_top`

## Requirements
- R1: mode_reg[1:0] selects the word length N: 00 = 16, 01 = 18, 10 = 20 bits; the reserved code 11 acts as 16 bits.
- R2: mode_reg[3:2] selects the framing: 00 = left-justified, 01 = right-justified, 10 = I2S; the reserved code 11 acts as left-justified.
- R3: mode_reg[6] (0 = 32 bit clocks per frame, valid only for 16-bit left-justified; 1 = 64) and mode_reg[5:4] have no effect on the received words.
- R4: Data and word clock are taken at rising edges of the bit clock, after a two-flip-flop synchronizer in the system-clock domain.
- R5: In I2S the left channel is the half frame with the word clock low. In left- and right-justified framing the left channel is the half with the word clock high.
- R6: Left-justified: the MSB is the bit taken at the first rising bit-clock edge that sees the new word-clock level, followed by the next N-1 bits.
- R7: I2S: the MSB is the bit taken one bit-clock period after that first edge, followed by the next N-1 bits.
- R8: Right-justified: the word is the last N bits taken before the word-clock transition that ends the half frame, with the LSB last.
- R9: Each output word carries the N received bits in bits 31 down to 32-N, MSB at bit 31; all lower bits are zero.
- R10: After every right half that follows a left half, pair_valid is high for exactly one system clock, with both words presented together. The outputs hold their value between pulses.
- R11: During reset pair_valid, left_out and right_out are zero. A half frame cut off by reset, and a right half with no preceding left half, produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 7 | Mode register: length [1:0], framing [3:2], unused [5:4], ratio [6] |
| bclk_in | input | 1 | External bit clock |
| wclk_in | input | 1 | External word (left/right) clock |
| sdata_in | input | 1 | External serial data |
| left_out | output | 32 | Left sample, MSB-aligned |
| right_out | output | 32 | Right sample, MSB-aligned |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The sweep runs every framing at every word length with 32 bit clocks per half frame. It adds the 16-bit left-justified case at 16 bit clocks per half. The padding bits around the sample are driven with a non-zero pattern, so a window that is one bit early or late, or that is taken from the wrong end of the half, shows up as a changed word. The sample values are chosen to separate the failure modes:
- all ones, MSB only and LSB only expose alignment and masking faults;
- zero and complemented right channels expose swapped channels;
- hashed values expose bit-order faults.

Further runs set the reserved codes and the unused bits, and one starts the stream with a cut-off left half followed by an orphan right half, to check that these are discarded.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'b00,
        FMT_RIGHT = 2'b01,
        FMT_I2S   = 2'b10
    } fmt_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_SKIP,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

    // framing code; reserved 11 behaves as left-justified
    function automatic fmt_e fmt_decode(input logic [1:0] code);
        unique case (code)
            2'b01:   return FMT_RIGHT;
            2'b10:   return FMT_I2S;
            default: return FMT_LEFT;
        endcase
    endfunction

    // length code; reserved 11 behaves as 16 bits
    function automatic logic [4:0] len_decode(input logic [1:0] code);
        unique case (code)
            2'b01:   return 5'd18;
            2'b10:   return 5'd20;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser import pcm_rx_pkg::*; #(
    parameter int OUT_W   = 32,
    parameter int MAX_LEN = 20,
    parameter int CNT_W   = 6,
    parameter int LEN_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s,
    input  logic             wclk_s,
    input  logic             sdat_s,
    input  fmt_e             fmt,
    input  logic [LEN_W-1:0] len,
    output logic             half_done,
    output logic             half_ws,
    output logic [OUT_W-1:0] half_word
);

    logic               bclk_q;
    logic               primed_q;
    logic               ws_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [MAX_LEN-1:0] sh_q;

    logic               rise;
    logic               boundary;
    logic [CNT_W-1:0]   pos;
    logic [CNT_W-1:0]   first_idx;
    logic               take;
    logic [MAX_LEN-1:0] sh_base;
    logic [MAX_LEN-1:0] sh_next;

    assign rise      = bclk_s & ~bclk_q;
    assign boundary  = rise & primed_q & (wclk_s != ws_q);
    // position of the arriving bit inside its half frame
    assign pos       = boundary ? '0 : cnt_q;
    assign first_idx = (fmt == FMT_I2S) ? CNT_W'(1) : '0;
    assign take      = (fmt == FMT_RIGHT) ||
                       ((pos >= first_idx) && (pos < first_idx + CNT_W'(len)));
    assign sh_base   = boundary ? '0 : sh_q;
    assign sh_next   = take ? {sh_base[MAX_LEN-2:0], sdat_s} : sh_base;

    function automatic logic [OUT_W-1:0] align_word(
        input logic [MAX_LEN-1:0] raw,
        input logic [LEN_W-1:0]   n
    );
        logic [OUT_W-1:0] ext;
        logic [OUT_W-1:0] mask;
        ext  = OUT_W'(raw);
        mask = (OUT_W'(1) << n) - OUT_W'(1);
        return (ext & mask) << (OUT_W - int'(n));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            primed_q  <= 1'b0;
            ws_q      <= 1'b0;
            cnt_q     <= '0;
            sh_q      <= '0;
            half_done <= 1'b0;
            half_ws   <= 1'b0;
            half_word <= '0;
        end else begin
            bclk_q    <= bclk_s;
            half_done <= boundary;
            if (boundary) begin
                half_word <= align_word(sh_q, len);
                half_ws   <= ws_q;
            end
            if (rise) begin
                primed_q <= 1'b1;
                ws_q     <= wclk_s;
                sh_q     <= sh_next;
                if (boundary)
                    cnt_q <= CNT_W'(1);
                else if (cnt_q != '1)
                    cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pcm_rx_fsm.sv
module pcm_rx_fsm import pcm_rx_pkg::*; #(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic             half_done,
    input  logic             half_ws,
    input  logic [OUT_W-1:0] half_word,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             pair_valid
);

    rx_state_e        st_q;
    rx_state_e        st_d;
    logic             done_left;
    logic [OUT_W-1:0] hold_q;

    // left level of the word clock depends on framing
    assign done_left = (fmt == FMT_I2S) ? ~half_ws : half_ws;

    always_comb begin
        st_d = st_q;
        if (half_done) begin
            unique case (st_q)
                ST_LEFT:  st_d = done_left ? ST_RIGHT : ST_LEFT;
                ST_RIGHT: st_d = done_left ? ST_SKIP  : ST_LEFT;
                ST_WAIT,
                ST_SKIP:  st_d = done_left ? ST_SKIP  : ST_LEFT;
                default:  st_d = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WAIT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            left_out   <= '0;
            right_out  <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (half_done) begin
                unique case (st_q)
                    ST_LEFT: begin
                        if (done_left) hold_q <= half_word;
                    end
                    ST_RIGHT: begin
                        if (!done_left) begin
                            left_out   <= hold_q;
                            right_out  <= half_word;
                            pair_valid <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pcm_rx_top.sv
module pcm_rx_top import pcm_rx_pkg::*; #(
    parameter int OUT_W       = 32,
    parameter int MAX_LEN     = 20,
    parameter int SYNC_STAGES = 2,
    parameter int CFG_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] mode_reg,
    input  logic             bclk_in,
    input  logic             wclk_in,
    input  logic             sdata_in,
    output logic [OUT_W-1:0] left_out,
    output logic [OUT_W-1:0] right_out,
    output logic             pair_valid
);

    localparam int CNT_W = $clog2(OUT_W) + 1;
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    logic [2:0]       pins_s;
    fmt_e             fmt;
    logic [LEN_W-1:0] len;
    logic             half_done;
    logic             half_ws;
    logic [OUT_W-1:0] half_word;
    logic             cfg_unused;

    // framing follows word-clock edges, so the ratio and output bits need no logic
    assign cfg_unused = ^mode_reg[CFG_W-1:4];
    assign fmt        = fmt_decode(mode_reg[3:2]);
    assign len        = LEN_W'(len_decode(mode_reg[1:0]));

    pcm_rx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bclk_in, wclk_in, sdata_in}),
        .sync_out (pins_s)
    );

    pcm_rx_deser #(
        .OUT_W   (OUT_W),
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W),
        .LEN_W   (LEN_W)
    ) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (pins_s[2]),
        .wclk_s    (pins_s[1]),
        .sdat_s    (pins_s[0]),
        .fmt       (fmt),
        .len       (len),
        .half_done (half_done),
        .half_ws   (half_ws),
        .half_word (half_word)
    );

    pcm_rx_fsm #(
        .OUT_W (OUT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .half_done  (half_done),
        .half_ws    (half_ws),
        .half_word  (half_word),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk import pcm_rx_pkg::*; #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       len_code,
    input logic [OUT_W-1:0] left_out,
    input logic [OUT_W-1:0] right_out,
    input logic             pair_valid,
    input logic             half_done
);

    logic [4:0]       n;
    logic [OUT_W-1:0] low_mask;

    assign n        = len_decode(len_code);
    assign low_mask = (OUT_W'(1) << (OUT_W - int'(n))) - OUT_W'(1);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

    // R9
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (((left_out & low_mask) == '0) && ((right_out & low_mask) == '0)));

    // R10
    after_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(half_done));

endmodule

bind pcm_rx_top pcm_rx_chk #(.OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .len_code   (mode_reg[1:0]),
    .left_out   (left_out),
    .right_out  (right_out),
    .pair_valid (pair_valid),
    .half_done  (half_done)
);

// File: tb/test_pcm_rx_top.sv
module test_pcm_rx_top;

    localparam int CLK_PERIOD = 10;
    localparam int BCLK_HALF  = 4;
    localparam int FRAMES     = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  mode_reg = '0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdat = 1'b0;
    logic [31:0] left_out;
    logic [31:0] right_out;
    logic        pair_valid;

    int          checks = 0;
    int          fails = 0;
    int          got = 0;
    string       cur_tag = "";
    logic [31:0] exp_l [FRAMES];
    logic [31:0] exp_r [FRAMES];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_rx_top i_pcm_rx_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_reg   (mode_reg),
        .bclk_in    (bclk),
        .wclk_in    (wclk),
        .sdata_in   (sdat),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // R10: compare every presented pair with the expected frame
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            if (got < FRAMES) begin
                check({cur_tag, " left"},  left_out,  exp_l[got]);
                check({cur_tag, " right"}, right_out, exp_r[got]);
            end
            got++;
        end
    end

    function automatic logic [19:0] pat(input int f, input int ch, input int n);
        logic [19:0] m;
        logic [19:0] base;
        m = 20'((32'd1 << n) - 1);
        if (f < 4) begin
            base = (f == 0) ? m : (f == 1) ? (20'd1 << (n - 1)) : (f == 2) ? 20'd1 : 20'd0;
            return (ch != 0) ? (~base & m) : base;
        end
        return 20'(f * 40503 + ch * 9973 + n * 211) & m;
    endfunction

    // R4: data and word clock change while the bit clock is low
    task automatic send_bit(input logic ws, input logic b);
        @(negedge clk);
        bclk = 1'b0; wclk = ws; sdat = b;
        repeat (BCLK_HALF) @(negedge clk);
        bclk = 1'b1;
        repeat (BCLK_HALF - 1) @(negedge clk);
    endtask

    task automatic send_half(input logic ws, input logic [19:0] w, input int n, input int fmt, input int r);
        for (int i = 0; i < r; i++) begin
            logic junk;
            logic b;
            junk = (i % 3 == 0);
            if (fmt == 2)      b = (i >= 1 && i <= n) ? w[n - i] : junk;        // R7
            else if (fmt == 1) b = (i >= r - n) ? w[r - 1 - i] : junk;          // R8
            else               b = (i < n) ? w[n - 1 - i] : junk;               // R6
            send_bit(ws, b);
        end
    endtask

    task automatic run_mode(input logic [1:0] fmtb, input logic [1:0] lenb, input logic ratio64,
                            input logic [1:0] hi54, input logic lead_left, input string tag);
        int   n;
        int   r;
        int   fmt;
        logic lv;
        n   = (lenb == 2'b01) ? 18 : (lenb == 2'b10) ? 20 : 16;
        fmt = (fmtb == 2'b01) ? 1 : (fmtb == 2'b10) ? 2 : 0;
        r   = ratio64 ? 32 : 16;
        lv  = (fmt == 2) ? 1'b0 : 1'b1;                                   // R5
        @(negedge clk);
        rst_n = 1'b0;
        bclk = 1'b0;
        wclk = lead_left ? lv : ~lv;
        mode_reg = {ratio64, hi54, fmtb, lenb};
        repeat (3) @(negedge clk);
        // R11 reset state
        check({tag, " R11 reset valid"}, 32'(pair_valid), 32'd0);
        check({tag, " R11 reset left"},  left_out,  32'd0);
        check({tag, " R11 reset right"}, right_out, 32'd0);
        for (int f = 0; f < FRAMES; f++) begin
            exp_l[f] = 32'(pat(f, 0, n)) << (32 - n);                     // R9
            exp_r[f] = 32'(pat(f, 1, n)) << (32 - n);
        end
        cur_tag = tag;
        got = 0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        if (lead_left) begin
            // R11 cut-off left half and orphan right half are dropped
            for (int i = 0; i < 5; i++) send_bit(lv, 1'b1);
            send_half(~lv, 20'hA5A5A, n, fmt, r);
        end else begin
            for (int i = 0; i < 3; i++) send_bit(~lv, 1'b1);
        end
        for (int f = 0; f < FRAMES; f++) begin
            send_half(lv,  pat(f, 0, n), n, fmt, r);
            send_half(~lv, pat(f, 1, n), n, fmt, r);
        end
        send_bit(lv, 1'b0);
        send_bit(lv, 1'b1);
        repeat (12) @(negedge clk);
        // R10 one pulse per frame
        check({tag, " R10 pair count"}, 32'(got), 32'(FRAMES));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        run_mode(2'b00, 2'b00, 1'b0, 2'b00, 1'b0, "R3 R6 LJ16 ratio32");
        run_mode(2'b00, 2'b00, 1'b1, 2'b00, 1'b0, "R1 R2 R6 LJ16");
        run_mode(2'b01, 2'b00, 1'b1, 2'b00, 1'b0, "R2 R8 RJ16");
        run_mode(2'b10, 2'b00, 1'b1, 2'b00, 1'b0, "R5 R7 I2S16");
        run_mode(2'b00, 2'b01, 1'b1, 2'b00, 1'b0, "R1 R6 LJ18");
        run_mode(2'b01, 2'b01, 1'b1, 2'b00, 1'b0, "R1 R8 RJ18");
        run_mode(2'b10, 2'b01, 1'b1, 2'b00, 1'b0, "R1 R7 I2S18");
        run_mode(2'b00, 2'b10, 1'b1, 2'b00, 1'b0, "R4 R9 LJ20");
        run_mode(2'b01, 2'b10, 1'b1, 2'b00, 1'b0, "R8 R9 RJ20");
        run_mode(2'b10, 2'b10, 1'b1, 2'b00, 1'b0, "R5 R7 I2S20");
        run_mode(2'b00, 2'b10, 1'b1, 2'b11, 1'b1, "R3 R11 LJ20 lead");
        run_mode(2'b11, 2'b11, 1'b1, 2'b00, 1'b0, "R1 R2 reserved codes");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule